// File: doc/BRIEF.md
# Free Buffer Watermark Monitor

This block watches how many buffer blocks remain free in a shared packet memory and compares that number with three programmable levels. Each level has its own action. Crossing the alert level sets a sticky interrupt status bit. Crossing the flow-control level requests one pause frame. Crossing the receive-reserve level halts the receive path, so that the local transmitter always keeps some memory.

The receive halt takes effect only at frame boundaries. A frame that is already arriving when the halt comes on runs to its end normally. A frame whose start strobe arrives while the halt is active is marked as dropped until its end strobe. Writing zero to a level turns off the action tied to it. The free-block count and all three levels share one width, set by a parameter.

Top module: `fbm_watermark_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `irq_flag`, `pause_req`, `rx_halt` and `rx_drop` are 0. The remembered "below" state of every level is cleared, so the first cycle after reset counts as not-below.
- R2: A level counts as "below" in a cycle when it is nonzero and `free_cnt` is less than it. When the alert comparison becomes below (it was not below in the previous cycle), `irq_flag` is 1 from the next cycle on.
- R3: `irq_flag` stays at 1 until a cycle with `irq_clr` high, and it reads 0 from the cycle after that. If a new crossing and `irq_clr` happen in the same cycle, the flag is set.
- R4: `pause_req` is high for exactly one cycle, the cycle after each not-below to below change of the flow-control comparison. It does not repeat while the count stays below.
- R5: `rx_halt` is 1 in the cycle after any cycle in which the reserve comparison is below. It is 0 in the cycle after any cycle in which it is not below (that is, `free_cnt` is greater than or equal to the level).
- R6: A level of zero never produces an interrupt set, a pause pulse or a halt, whatever the value of `free_cnt`.
- R7: In a cycle with `rx_sof` high, `rx_drop` takes the value of `rx_halt` in that cycle, and the new value is visible in the next cycle. In a cycle with `rx_eof` high and `rx_sof` low, `rx_drop` is cleared for the next cycle. Otherwise it holds its value. A halt that starts during a frame therefore does not mark that frame.
- R8: The comparison is strict. A count equal to a level is not below that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| free_cnt | input | CNT_W | Number of free buffer blocks |
| lvl_alert | input | CNT_W | Interrupt level (0 = off) |
| lvl_pause | input | CNT_W | Flow-control pause level (0 = off) |
| lvl_reserve | input | CNT_W | Receive reserve level (0 = off) |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt status |
| rx_sof | input | 1 | Receive frame start strobe |
| rx_eof | input | 1 | Receive frame end strobe |
| irq_flag | output | 1 | Sticky watermark interrupt status |
| pause_req | output | 1 | One-cycle pause frame request |
| rx_halt | output | 1 | Receive path halted |
| rx_drop | output | 1 | Current frame is being dropped |

## Verification
The bench sweeps every level value of a 4-bit configuration, with counts falling and then rising through the whole range. This covers equality with each level, where a less-or-equal compare would halt one step early, and level zero, where a design that forgot the disable would halt or pulse at count 0. Periodic clear strobes are placed on crossing cycles, so a design that gives clear priority over set loses an interrupt. Frames are started just before and just after halt changes, so a design that samples the halt at the end of a frame, or one that truncates the current frame, marks the wrong frame. A pause request that stays high, or that repeats while the count stays below, shows up as a mismatch on the cycles that follow the crossing.

// File: rtl/fbm_pkg.sv
// Package for the free buffer watermark monitor.
// Purpose: names the three watermark levels and gives their count.
// Assumes: the index values are used to select entries of per-level arrays.
package fbm_pkg;
    typedef enum logic [1:0] {
        WM_ALERT   = 2'd0,
        WM_PAUSE   = 2'd1,
        WM_RESERVE = 2'd2
    } wm_sel_e;

    localparam int unsigned WM_N = 3;
endpackage

// File: rtl/fbm_level_track.sv
// Compares the free-block count with one level, using a strict less-than.
// Also remembers the result of the previous cycle and flags a new fall below the level.
// Assumes: a level of zero means the level is turned off.
module fbm_level_track #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    output logic             below,
    output logic             below_q,
    output logic             fall
);
    localparam logic [CNT_W-1:0] LVL_OFF = '0;

    // Current comparison; a zero level disables it.
    always_comb begin
        below = (level != LVL_OFF) && (count < level);
        fall  = below && !below_q;
    end

    // Remember last cycle's comparison for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) below_q <= 1'b0;
        else        below_q <= below;
    end

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        below |=> below_q); // R5
endmodule

// File: rtl/fbm_irq_sticky.sv
// Sticky interrupt status bit for the watermark alert level.
// Assumes: irq_clr is a write-one-to-clear strobe from the host.
// A new crossing wins over a clear in the same cycle.
module fbm_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic clr,
    output logic flag
);
    // Set on a fall below the level, clear on the host strobe; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (fall) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> flag); // R2
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R3
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fall) |=> !flag); // R3
endmodule

// File: rtl/fbm_rx_gate.sv
// Frame-boundary receive gate.
// It samples the halt at each frame start and holds the drop mark until that frame ends.
// Assumes: start and end strobes come from the receive MAC. A start in the same cycle as an end belongs to the next frame.
module fbm_rx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic sof,
    input  logic eof,
    output logic drop
);
    // Capture the halt at frame start; release at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)   drop <= 1'b0;
        else if (sof) drop <= halt;
        else if (eof) drop <= 1'b0;
    end

    AST_DROP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && halt) |=> drop); // R7
    AST_DROP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !eof) |=> $stable(drop)); // R7
    AST_DROP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && !sof) |=> !drop); // R7
endmodule

// File: rtl/fbm_watermark_mon.sv
// Top of the free buffer watermark monitor.
// Three level trackers drive a sticky interrupt, a one-cycle pause request and a receive halt.
// The receive halt is applied at frame boundaries.
// Assumes: free_cnt and the levels are synchronous to clk. Reset is synchronous and active low.
module fbm_watermark_mon
    import fbm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [CNT_W-1:0] lvl_alert,
    input  logic [CNT_W-1:0] lvl_pause,
    input  logic [CNT_W-1:0] lvl_reserve,
    input  logic             irq_clr,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             irq_flag,
    output logic             pause_req,
    output logic             rx_halt,
    output logic             rx_drop
);
    localparam int unsigned IX_A = int'(WM_ALERT);
    localparam int unsigned IX_P = int'(WM_PAUSE);
    localparam int unsigned IX_R = int'(WM_RESERVE);

    logic [CNT_W-1:0] lvl_v [WM_N];
    logic [WM_N-1:0]  below_v;
    logic [WM_N-1:0]  below_q_v;
    logic [WM_N-1:0]  fall_v;

    // Gather the levels into an array indexed by watermark kind.
    always_comb begin
        lvl_v[IX_A] = lvl_alert;
        lvl_v[IX_P] = lvl_pause;
        lvl_v[IX_R] = lvl_reserve;
    end

    for (genvar g = 0; g < WM_N; g++) begin : g_lvl
        fbm_level_track #(.CNT_W(CNT_W)) i_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (free_cnt),
            .level   (lvl_v[g]),
            .below   (below_v[g]),
            .below_q (below_q_v[g]),
            .fall    (fall_v[g])
        );
    end

    fbm_irq_sticky i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .fall  (fall_v[IX_A]),
        .clr   (irq_clr),
        .flag  (irq_flag)
    );

    // One pause request per fall below the flow-control level.
    always_ff @(posedge clk) begin
        if (!rst_n) pause_req <= 1'b0;
        else        pause_req <= fall_v[IX_P];
    end

    // The halt follows the reserve comparison with one register stage.
    assign rx_halt = below_q_v[IX_R];

    fbm_rx_gate i_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (rx_halt),
        .sof   (rx_sof),
        .eof   (rx_eof),
        .drop  (rx_drop)
    );

    AST_PAUSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req); // R4
    AST_ZERO_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_reserve == '0) |=> !rx_halt); // R6
    AST_ZERO_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_pause == '0) |=> !pause_req); // R6
    AST_EQUAL_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt >= lvl_reserve) |=> !rx_halt); // R8
endmodule

// File: tb/test_fbm_watermark_mon.sv
`timescale 1ns/1ps
module test_fbm_watermark_mon;
    localparam int unsigned W = 4;
    localparam int unsigned MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] free_cnt = '0, lvl_alert = '0, lvl_pause = '0, lvl_reserve = '0;
    logic         irq_clr = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic         irq_flag, pause_req, rx_halt, rx_drop;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Reference state
    bit m_ba = 0, m_bp = 0, m_irq = 0, m_pause = 0, m_halt = 0, m_drop = 0;

    always #2.5 clk = ~clk;

    fbm_watermark_mon #(.CNT_W(W)) i_fbm_watermark_mon (
        .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt),
        .lvl_alert(lvl_alert), .lvl_pause(lvl_pause), .lvl_reserve(lvl_reserve),
        .irq_clr(irq_clr), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .irq_flag(irq_flag), .pause_req(pause_req), .rx_halt(rx_halt), .rx_drop(rx_drop)
    );

    task automatic chk(input string req, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
        end
    endtask

    // Apply the current inputs for one clock edge, advance the reference, then compare.
    task automatic step();
        bit ba, bp, br;
        ba = (lvl_alert != 0) && (free_cnt < lvl_alert);
        bp = (lvl_pause != 0) && (free_cnt < lvl_pause);
        br = (lvl_reserve != 0) && (free_cnt < lvl_reserve);
        if (!rst_n) begin
            m_irq = 0; m_pause = 0; m_halt = 0; m_drop = 0; ba = 0; bp = 0;
        end else begin
            m_irq   = (ba && !m_ba) ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
            m_pause = bp && !m_bp;
            m_drop  = rx_sof ? m_halt : (rx_eof ? 1'b0 : m_drop);
            m_halt  = br;
        end
        m_ba = ba; m_bp = bp;
        @(posedge clk); #1; cyc++;
        if (!rst_n) begin
            chk("R1", "irq_flag", irq_flag, 1'b0);
            chk("R1", "pause_req", pause_req, 1'b0);
            chk("R1", "rx_halt", rx_halt, 1'b0);
            chk("R1", "rx_drop", rx_drop, 1'b0);
        end else begin
            chk("R2/R3", "irq_flag", irq_flag, m_irq);
            chk("R4", "pause_req", pause_req, m_pause);
            chk("R5", "rx_halt", rx_halt, m_halt);
            chk("R7", "rx_drop", rx_drop, m_drop);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        // R1: reset state with counts already below every level
        free_cnt = 4'd1; lvl_alert = 4'd8; lvl_pause = 4'd8; lvl_reserve = 4'd8;
        repeat (3) step();
        rst_n = 1'b1;
        // R1/R2: the first cycle after reset counts as not-below, so a fall is seen at once
        step();
        chk("R2", "irq set right after reset", irq_flag, 1'b1);
        chk("R4", "pause pulse right after reset", pause_req, 1'b1);
        step();
        chk("R4", "pause not repeated", pause_req, 1'b0);

        // R8: equality is not below
        free_cnt = 4'd9; irq_clr = 1'b1; lvl_reserve = 4'd6; step(); irq_clr = 1'b0;
        chk("R3", "irq cleared", irq_flag, 1'b0);
        free_cnt = 4'd6; step();
        chk("R8", "count equal to level gives no halt", rx_halt, 1'b0);
        free_cnt = 4'd5; step();
        chk("R5", "halt when below", rx_halt, 1'b1);

        // R3: set wins over a clear in the same cycle
        free_cnt = 4'd15; step();
        free_cnt = 4'd2; irq_clr = 1'b1; step(); irq_clr = 1'b0;
        chk("R3", "set has priority over clear", irq_flag, 1'b1);

        // R7: a halt that rises mid-frame does not mark the current frame
        free_cnt = 4'd15; step(); step();
        rx_sof = 1'b1; step(); rx_sof = 1'b0;
        free_cnt = 4'd0; step(); step();
        chk("R7", "halt active mid-frame", rx_halt, 1'b1);
        chk("R7", "current frame not dropped", rx_drop, 1'b0);
        rx_eof = 1'b1; step(); rx_eof = 1'b0;
        rx_sof = 1'b1; step(); rx_sof = 1'b0;
        chk("R7", "next frame dropped", rx_drop, 1'b1);
        free_cnt = 4'd15; step(); step();
        chk("R7", "drop held after halt release", rx_drop, 1'b1);
        rx_eof = 1'b1; step(); rx_eof = 1'b0;
        chk("R7", "drop cleared at end", rx_drop, 1'b0);

        // R6: zero levels disable everything, even at count 0
        lvl_alert = 0; lvl_pause = 0; lvl_reserve = 0; irq_clr = 1'b1; step(); irq_clr = 1'b0;
        free_cnt = 4'd0; step(); step();
        chk("R6", "no irq with zero level", irq_flag, 1'b0);
        chk("R6", "no halt with zero level", rx_halt, 1'b0);
        chk("R6", "no pause with zero level", pause_req, 1'b0);

        // Sweep: every level value, counts falling then rising, with frames and clears
        for (int t = 0; t <= int'(MAXV); t++) begin
            lvl_alert   = W'(t);
            lvl_pause   = W'((t + 5) % (MAXV + 1));
            lvl_reserve = W'((t * 3) % (MAXV + 1));
            for (int k = 0; k < 2 * int'(MAXV + 1); k++) begin
                int c;
                c = (k <= int'(MAXV)) ? int'(MAXV) - k : k - int'(MAXV + 1);
                free_cnt = W'(c);
                irq_clr  = ((k + t) % 5) == 0;
                rx_sof   = ((k + t) % 7) == 0;
                rx_eof   = ((k + t) % 7) == 3 || ((k + t) % 11) == 0;
                step();
            end
            // R6: reserve level 0 gives no halt across the whole sweep
            if (lvl_reserve == 0) chk("R6", "zero reserve after sweep", rx_halt, 1'b0);
        end
        irq_clr = 0; rx_sof = 0; rx_eof = 0;

        // R1: reset again mid-activity
        free_cnt = 4'd0; lvl_reserve = 4'd4; step();
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule